// File: doc/BRIEF.md
# Interrupt, Halt and Reset Controller for a Dual-Master I2C Command Engine

This block collects the event and error pulses of up to two I2C masters, each with two command queues. It records them in a 32-bit sticky status word. A programmable enable word selects which status bits drive a single level-sensitive interrupt line. Software clears status bits in either of two ways: it writes ones to a clear register, or it issues a global clear command that wipes the whole word at once.

The block also sequences two maintenance operations. A halt request sends a one-cycle halt strobe to the chosen master. When that master acknowledges, a per-master halt-acknowledge status bit is set. A reset command carries a per-master field. It strobes every master whose field is non-zero, then waits until each of them has acknowledged. Only then does it raise a single reset-done status bit.

Register access uses a plain write/read port with a 3-bit word index. Read data is registered and appears in the cycle after the read strobe.

Top module: `irq_halt_ctrl`

Register indices: 0 status (read only), 1 enable mask (read/write), 2 clear (write only), 3 global clear (write only), 4 halt request (write only), 5 reset command (write only).

## Requirements
- R1: After synchronous reset the status word, enable mask, interrupt line, read data, halt strobes and reset strobes are all zero.
- R2: Status bit positions for master m (m = 0 or 1): read done sets bit 12*m, a report on queue q sets bit 12*m+4+4*q, and a NACK on queue q sets bit 27+2*m+q. A pulse sets its bit at the clock edge that samples it.
- R3: The eight non-NACK fault lines k = 0..7 of master m set bits 12*m plus 1, 2, 5, 6, 7, 9, 10 and 11 (in that order of k). All faults and NACKs of master 0 together give 0x18000ee6, and those of master 1 give 0x60ee6000.
- R4: Writing index 2 clears exactly the status bits written as one. Bits written as zero keep their value.
- R5: Writing index 3 with bit 0 set clears the whole status word. Writing index 3 with bit 0 clear changes nothing.
- R6: When an event and a clear (per-bit or global) hit the same bit in the same cycle, the bit ends set.
- R7: The interrupt line is high exactly when some status bit is set whose enable-mask bit is also set. It changes at the same edge as the status or mask. Masking never hides a bit from the status word.
- R8: Writing index 4 with bit m set drives halt strobe m high for the following cycle. An acknowledge from master m while its halt is outstanding sets status bit 25+m.
- R9: A halt acknowledge from a master with no outstanding halt request leaves the status word unchanged.
- R10: A reset command written to index 5 targets master m when any of bits 4+8*m through 9+8*m is set. For example, 0x3f1 targets master 0, 0x3f001 targets master 1, and 0x0f73f3f7 targets both. Each targeted master sees a one-cycle reset strobe. Status bit 24 is set at the edge that samples the last outstanding acknowledge.
- R11: A reset command that targets no master, or that arrives while a reset is outstanding, produces no strobe. A reset acknowledge from a master that is not being waited on has no effect.
- R12: Reading index 0 returns the status word and index 1 returns the enable mask, on the read data port one cycle after the read strobe. The write-only indices read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| rd_done_i | input | NUM_MASTERS | Read-done pulse per master |
| report_i | input | 2*NUM_MASTERS | Queue report pulse, index m*2+q |
| nack_i | input | 2*NUM_MASTERS | Queue NACK pulse, index m*2+q |
| fault_i | input | 8*NUM_MASTERS | Other error pulses, index m*8+k |
| halt_ack_i | input | NUM_MASTERS | Halt acknowledge pulse per master |
| rst_ack_i | input | NUM_MASTERS | Reset acknowledge pulse per master |
| halt_req_o | output | NUM_MASTERS | One-cycle halt strobe per master |
| rst_req_o | output | NUM_MASTERS | One-cycle reset strobe per master |
| irq_o | output | 1 | Level interrupt |

## Verification
Every event input of both masters is pulsed alone and then cleared. This separates each bit position and catches swapped or shifted lanes. Pulsing all error lines of one master at once checks that the two error groups are disjoint and complete. Clears are tried per bit, by subset, globally and colliding with a new event, which tells sticky storage apart from priority mistakes. The halt and reset sequences are driven with solicited, unsolicited, partial and overlapping acknowledges, which tells the outstanding-request tracking apart from a block that simply forwards every acknowledge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int WORD_W      = 32;
  localparam int ADDR_W      = 3;
  localparam int QUEUES      = 2;
  localparam int FAULTS      = 8;
  localparam int RST_FIELD_W = 6;

  localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CLEAR  = 3'd2;
  localparam logic [ADDR_W-1:0] A_GCLR   = 3'd3;
  localparam logic [ADDR_W-1:0] A_HALT   = 3'd4;
  localparam logic [ADDR_W-1:0] A_RESET  = 3'd5;

  localparam int RESET_DONE_POS = 24;

  // per-master lane of 12 status bits
  function automatic int rd_done_pos(input int m);
    return 12 * m;
  endfunction

  function automatic int report_pos(input int m, input int q);
    return 12 * m + 4 + 4 * q;
  endfunction

  function automatic int nack_pos(input int m, input int q);
    return 27 + QUEUES * m + q;
  endfunction

  function automatic int halt_ack_pos(input int m);
    return 25 + m;
  endfunction

  // fault k lands in the lane gaps left by read-done and the reports
  function automatic int fault_pos(input int m, input int k);
    int off;
    if (k < 2)      off = 1 + k;
    else if (k < 5) off = 5 + (k - 2);
    else            off = 9 + (k - 5);
    return 12 * m + off;
  endfunction

  function automatic int reset_field_lo(input int m);
    return 4 + 8 * m;
  endfunction

endpackage

// File: rtl/irqc_event_map.sv
module irqc_event_map
  import irqc_pkg::*;
#(
  parameter int NUM_MASTERS = 2
) (
  input  logic [NUM_MASTERS-1:0]        rd_done_i,
  input  logic [NUM_MASTERS*QUEUES-1:0] report_i,
  input  logic [NUM_MASTERS*QUEUES-1:0] nack_i,
  input  logic [NUM_MASTERS*FAULTS-1:0] fault_i,
  input  logic [NUM_MASTERS-1:0]        halt_ev_i,
  input  logic                          reset_done_i,
  output logic [WORD_W-1:0]             set_o
);

  always_comb begin
    set_o = '0;
    for (int m = 0; m < NUM_MASTERS; m++) begin
      set_o[rd_done_pos(m)]  = rd_done_i[m];
      set_o[halt_ack_pos(m)] = halt_ev_i[m];
      for (int q = 0; q < QUEUES; q++) begin
        set_o[report_pos(m, q)] = report_i[m*QUEUES+q];
        set_o[nack_pos(m, q)]   = nack_i[m*QUEUES+q];
      end
      for (int k = 0; k < FAULTS; k++) begin
        set_o[fault_pos(m, k)] = fault_i[m*FAULTS+k];
      end
    end
    set_o[RESET_DONE_POS] = reset_done_i;
  end

endmodule

// File: rtl/irqc_status_reg.sv
module irqc_status_reg
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] set_i,
  input  logic [WORD_W-1:0] clr_i,
  input  logic              mask_we,
  input  logic [WORD_W-1:0] mask_wdata,
  output logic [WORD_W-1:0] status_q,
  output logic [WORD_W-1:0] mask_q,
  output logic              irq_q
);

  logic [WORD_W-1:0] status_d;
  logic [WORD_W-1:0] mask_d;

  // a fresh event outranks a clear of the same bit
  always_comb begin
    status_d = (status_q & ~clr_i) | set_i;
    mask_d   = mask_we ? mask_wdata : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
      irq_q    <= |(status_d & mask_d);
    end
  end

endmodule

// File: rtl/irqc_halt_reset.sv
module irqc_halt_reset #(
  parameter int NUM_MASTERS = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   halt_wr,
  input  logic [NUM_MASTERS-1:0] halt_sel,
  input  logic                   rst_wr,
  input  logic [NUM_MASTERS-1:0] rst_target,
  input  logic [NUM_MASTERS-1:0] halt_ack_i,
  input  logic [NUM_MASTERS-1:0] rst_ack_i,
  output logic [NUM_MASTERS-1:0] halt_req_o,
  output logic [NUM_MASTERS-1:0] rst_req_o,
  output logic [NUM_MASTERS-1:0] halt_ev_o,
  output logic                   reset_done_o
);

  logic [NUM_MASTERS-1:0] halt_pend_q;
  logic [NUM_MASTERS-1:0] rst_wait_q;
  logic [NUM_MASTERS-1:0] rst_wait_left;
  logic                   rst_accept;

  always_comb begin
    halt_ev_o     = halt_ack_i & halt_pend_q;
    rst_wait_left = rst_wait_q & ~rst_ack_i;
    reset_done_o  = (|rst_wait_q) && (rst_wait_left == '0);
    rst_accept    = rst_wr && (rst_wait_q == '0) && (|rst_target);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_pend_q <= '0;
      halt_req_o  <= '0;
      rst_wait_q  <= '0;
      rst_req_o   <= '0;
    end else begin
      halt_pend_q <= (halt_pend_q & ~halt_ack_i) | (halt_wr ? halt_sel : '0);
      halt_req_o  <= halt_wr ? halt_sel : '0;
      rst_wait_q  <= rst_accept ? rst_target : rst_wait_left;
      rst_req_o   <= rst_accept ? rst_target : '0;
    end
  end

endmodule

// File: rtl/irq_halt_ctrl.sv
module irq_halt_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_MASTERS = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reg_we,
  input  logic                          reg_re,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [WORD_W-1:0]             reg_wdata,
  output logic [WORD_W-1:0]             reg_rdata,
  input  logic [NUM_MASTERS-1:0]        rd_done_i,
  input  logic [NUM_MASTERS*QUEUES-1:0] report_i,
  input  logic [NUM_MASTERS*QUEUES-1:0] nack_i,
  input  logic [NUM_MASTERS*FAULTS-1:0] fault_i,
  input  logic [NUM_MASTERS-1:0]        halt_ack_i,
  input  logic [NUM_MASTERS-1:0]        rst_ack_i,
  output logic [NUM_MASTERS-1:0]        halt_req_o,
  output logic [NUM_MASTERS-1:0]        rst_req_o,
  output logic                          irq_o
);

  logic [WORD_W-1:0]      ev_set;
  logic [WORD_W-1:0]      clr_vec;
  logic [WORD_W-1:0]      status_q;
  logic [WORD_W-1:0]      mask_q;
  logic [NUM_MASTERS-1:0] halt_ev;
  logic [NUM_MASTERS-1:0] rst_target;
  logic                   reset_done;
  logic                   wr_mask, wr_clear, wr_gclr, wr_halt, wr_reset;

  always_comb begin
    wr_mask  = reg_we && (reg_addr == A_MASK);
    wr_clear = reg_we && (reg_addr == A_CLEAR);
    wr_gclr  = reg_we && (reg_addr == A_GCLR) && reg_wdata[0];
    wr_halt  = reg_we && (reg_addr == A_HALT);
    wr_reset = reg_we && (reg_addr == A_RESET);
    clr_vec  = (wr_clear ? reg_wdata : '0) | (wr_gclr ? '1 : '0);
  end

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_target
    assign rst_target[m] = |reg_wdata[reset_field_lo(m) +: RST_FIELD_W];
  end

  irqc_event_map #(.NUM_MASTERS(NUM_MASTERS)) u_map (
    .rd_done_i    (rd_done_i),
    .report_i     (report_i),
    .nack_i       (nack_i),
    .fault_i      (fault_i),
    .halt_ev_i    (halt_ev),
    .reset_done_i (reset_done),
    .set_o        (ev_set)
  );

  irqc_status_reg u_stat (
    .clk        (clk),
    .rst        (rst),
    .set_i      (ev_set),
    .clr_i      (clr_vec),
    .mask_we    (wr_mask),
    .mask_wdata (reg_wdata),
    .status_q   (status_q),
    .mask_q     (mask_q),
    .irq_q      (irq_o)
  );

  irqc_halt_reset #(.NUM_MASTERS(NUM_MASTERS)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .halt_wr      (wr_halt),
    .halt_sel     (reg_wdata[NUM_MASTERS-1:0]),
    .rst_wr       (wr_reset),
    .rst_target   (rst_target),
    .halt_ack_i   (halt_ack_i),
    .rst_ack_i    (rst_ack_i),
    .halt_req_o   (halt_req_o),
    .rst_req_o    (rst_req_o),
    .halt_ev_o    (halt_ev),
    .reset_done_o (reset_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_re) begin
      case (reg_addr)
        A_STATUS: reg_rdata <= status_q;
        A_MASK:   reg_rdata <= mask_q;
        default:  reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int NUM_MASTERS = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   reg_we,
  input logic [ADDR_W-1:0]      reg_addr,
  input logic [WORD_W-1:0]      reg_wdata,
  input logic [NUM_MASTERS-1:0] halt_ack_i,
  input logic [NUM_MASTERS-1:0] rst_ack_i,
  input logic [NUM_MASTERS-1:0] halt_req_o,
  input logic [NUM_MASTERS-1:0] rst_req_o,
  input logic                   irq_o,
  input logic [WORD_W-1:0]      status_q,
  input logic [WORD_W-1:0]      mask_q,
  input logic [WORD_W-1:0]      ev_set
);

  logic [WORD_W-1:0]      clr_req;
  logic [NUM_MASTERS-1:0] halt_wr_bits;

  always_comb begin
    clr_req = '0;
    if (reg_we && reg_addr == A_CLEAR)                 clr_req = reg_wdata;
    else if (reg_we && reg_addr == A_GCLR && reg_wdata[0]) clr_req = '1;
    halt_wr_bits = (reg_we && reg_addr == A_HALT) ? reg_wdata[NUM_MASTERS-1:0] : '0;
  end

  p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    ((($past(status_q) & ~status_q) & ~$past(clr_req)) == '0));

  p_event_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (|ev_set) |=> ((status_q & $past(ev_set)) == $past(ev_set)));

  p_irq_level_r7: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|(status_q & mask_q)));

  p_halt_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    (halt_req_o & ~$past(halt_wr_bits)) == '0);

  p_reset_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    (|rst_req_o) |-> $past(reg_we && reg_addr == A_RESET));

  p_reset_done_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(status_q[RESET_DONE_POS]) |-> $past(|rst_ack_i));

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_halt
    p_halt_ack_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(status_q[halt_ack_pos(m)]) |-> $past(halt_ack_i[m]));
  end

endmodule

bind irq_halt_ctrl irqc_checker #(.NUM_MASTERS(NUM_MASTERS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .halt_ack_i (halt_ack_i),
  .rst_ack_i  (rst_ack_i),
  .halt_req_o (halt_req_o),
  .rst_req_o  (rst_req_o),
  .irq_o      (irq_o),
  .status_q   (status_q),
  .mask_q     (mask_q),
  .ev_set     (ev_set)
);

// File: tb/irq_halt_ctrl_test.sv
`timescale 1ns/1ps
module irq_halt_ctrl_test;

  localparam int NM = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NM-1:0]   rd_done_i = '0;
  logic [NM*2-1:0] report_i = '0;
  logic [NM*2-1:0] nack_i = '0;
  logic [NM*8-1:0] fault_i = '0;
  logic [NM-1:0]   halt_ack_i = '0;
  logic [NM-1:0]   rst_ack_i = '0;
  logic [NM-1:0]   halt_req_o;
  logic [NM-1:0]   rst_req_o;
  logic            irq_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  irq_halt_ctrl #(.NUM_MASTERS(NM)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_done_i(rd_done_i),
    .report_i(report_i), .nack_i(nack_i), .fault_i(fault_i),
    .halt_ack_i(halt_ack_i), .rst_ack_i(rst_ack_i), .halt_req_o(halt_req_o),
    .rst_req_o(rst_req_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle();
    @(negedge clk);
    rd_done_i = '0; report_i = '0; nack_i = '0; fault_i = '0;
    halt_ack_i = '0; rst_ack_i = '0;
  endtask

  function automatic int fpos(input int m, input int k);
    return 12*m + k + 1 + ((k >= 2) ? 2 : 0) + ((k >= 5) ? 1 : 0);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] exp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'b0, irq_o}, 0);
    check("R1 halt_req", {30'b0, halt_req_o}, 0);
    check("R1 rst_req", {30'b0, rst_req_o}, 0);
    check("R1 rdata", reg_rdata, 0);
    rd(3'd0, v); check("R1 status", v, 0);
    rd(3'd1, v); check("R1 mask", v, 0);
    // R12 readback
    wr(3'd1, 32'hA5C3_0F71);
    rd(3'd1, v); check("R12 mask readback", v, 32'hA5C3_0F71);
    for (int a = 2; a < 8; a++) begin
      rd(a[2:0], v); check("R12 write-only reads zero", v, 0);
    end
    wr(3'd1, 32'hFFFF_FFFF);

    // R2 / R3 single-event sweep with W1C clear (R4) and irq (R7)
    for (int m = 0; m < NM; m++) begin
      for (int e = 0; e < 13; e++) begin
        @(negedge clk);
        if (e == 0) begin rd_done_i[m] = 1'b1; exp = 32'h1 << (12*m); end
        else if (e < 3) begin report_i[m*2+e-1] = 1'b1; exp = 32'h1 << (12*m + 4*e); end
        else if (e < 5) begin nack_i[m*2+e-3] = 1'b1; exp = 32'h1 << (27 + 2*m + e - 3); end
        else begin fault_i[m*8+e-5] = 1'b1; exp = 32'h1 << fpos(m, e-5); end
        idle();
        check("R7 irq on enabled event", {31'b0, irq_o}, 1);
        rd(3'd0, v);
        check((e < 5) ? "R2 event position" : "R3 fault position", v, exp);
        wr(3'd2, exp);
        rd(3'd0, v); check("R4 cleared by W1C", v, 0);
        check("R7 irq low after clear", {31'b0, irq_o}, 0);
      end
    end

    // R3 error groups
    for (int m = 0; m < NM; m++) begin
      @(negedge clk);
      fault_i[m*8 +: 8] = 8'hFF; nack_i[m*2 +: 2] = 2'b11;
      idle();
      rd(3'd0, v); check("R3 error group", v, (m == 0) ? 32'h1800_0EE6 : 32'h60EE_6000);
      wr(3'd3, 32'h1);
    end

    // R4 partial clear
    @(negedge clk);
    rd_done_i = 2'b11; report_i = 4'b1001;
    idle();
    wr(3'd2, 32'h0001_0010);
    rd(3'd0, v); check("R4 partial clear keeps others", v, 32'h0010_1001);

    // R5 global clear
    wr(3'd3, 32'h2);
    rd(3'd0, v); check("R5 global clear bit0 low ignored", v, 32'h0010_1001);
    wr(3'd3, 32'h1);
    rd(3'd0, v); check("R5 global clear", v, 0);

    // R6 event vs clear collisions
    @(negedge clk);
    rd_done_i[0] = 1'b1; reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h1;
    @(negedge clk);
    rd_done_i = '0; reg_we = 1'b0; reg_wdata = '0;
    rd(3'd0, v); check("R6 event beats W1C", v, 32'h1);
    @(negedge clk);
    nack_i[3] = 1'b1; reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h1;
    @(negedge clk);
    nack_i = '0; reg_we = 1'b0; reg_wdata = '0;
    rd(3'd0, v); check("R6 event beats global clear", v, 32'h4000_0000);
    wr(3'd3, 32'h1);

    // R7 masking
    wr(3'd1, 32'h0);
    @(negedge clk); report_i[3] = 1'b1; idle();
    check("R7 masked bit no irq", {31'b0, irq_o}, 0);
    rd(3'd0, v); check("R7 masked bit still in status", v, 32'h0010_0000);
    wr(3'd1, 32'h0010_0000);
    check("R7 unmask raises irq", {31'b0, irq_o}, 1);
    wr(3'd1, 32'h0000_0001);
    check("R7 other mask bit no irq", {31'b0, irq_o}, 0);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd3, 32'h1);

    // R8 / R9 halt
    @(negedge clk); halt_ack_i = 2'b01; idle();
    rd(3'd0, v); check("R9 unsolicited halt ack", v, 0);
    wr(3'd4, 32'h2);
    check("R8 halt strobe m1", {30'b0, halt_req_o}, 32'h2);
    @(negedge clk);
    check("R8 halt strobe one cycle", {30'b0, halt_req_o}, 0);
    halt_ack_i = 2'b11; idle();
    rd(3'd0, v); check("R8 R9 halt ack m1 only", v, 32'h1 << 26);
    wr(3'd4, 32'h1);
    check("R8 halt strobe m0", {30'b0, halt_req_o}, 32'h1);
    @(negedge clk); halt_ack_i = 2'b01; idle();
    rd(3'd0, v); check("R8 halt ack m0", v, 32'h0600_0000);
    wr(3'd3, 32'h1);

    // R10 / R11 reset
    @(negedge clk); rst_ack_i = 2'b11; idle();
    rd(3'd0, v); check("R11 unsolicited reset ack", v, 0);
    wr(3'd5, 32'h1);
    check("R11 no-target command no strobe", {30'b0, rst_req_o}, 0);
    wr(3'd5, 32'h0003_F001);
    check("R10 m1 reset strobe", {30'b0, rst_req_o}, 32'h2);
    @(negedge clk); rst_ack_i = 2'b01; idle();
    rd(3'd0, v); check("R11 ack from unwaited master", v, 0);
    @(negedge clk); rst_ack_i = 2'b10; idle();
    rd(3'd0, v); check("R10 reset done m1", v, 32'h0100_0000);
    wr(3'd3, 32'h1);
    wr(3'd5, 32'h0F73_F3F7);
    check("R10 both reset strobes", {30'b0, rst_req_o}, 32'h3);
    @(negedge clk);
    check("R10 reset strobe one cycle", {30'b0, rst_req_o}, 0);
    rst_ack_i = 2'b01; idle();
    rd(3'd0, v); check("R10 partial ack no done", v, 0);
    wr(3'd5, 32'h0000_03F1);
    check("R11 command while busy ignored", {30'b0, rst_req_o}, 0);
    @(negedge clk); rst_ack_i = 2'b10; idle();
    rd(3'd0, v); check("R10 done after last ack", v, 32'h0100_0000);
    wr(3'd3, 32'h1);
    wr(3'd5, 32'h0000_03F1);
    check("R10 m0 reset strobe", {30'b0, rst_req_o}, 32'h1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule